// File: doc/BRIEF.md
# Video Memory DMA Engine

This block moves data into the three local memories of a video processor: a byte-wide pattern memory (VRAM), a word-wide colour table and a word-wide scroll table. Three modes are supported. A transfer reads words from an external bus with a 24-bit address. A fill writes one latched datum again and again. A copy reads from the destination memory and writes back into that same memory. Each pulse on `slot_i` marks one free memory-access slot, and the engine takes at most one step in it. The engine runs only while the DMA enable input is high and its own run flag is set.

The engine owns three registers: the destination address, the low byte of the source address and the 16-bit unit count. Software loads these registers through load strobes, and the engine updates them after each completed unit. The high and middle source bytes, the auto-increment step and the destination select are supplied from outside as plain inputs. External reads use a request/valid handshake. While a fetch is outstanding the engine stalls, and slots that arrive during the stall are dropped. The `busy_o` output is the run flag and serves as the DMA-active bit of the status word.

Top module: `vdp_dma_engine`

## Requirements
- R1: After reset `busy_o`, `ext_req_o` and all three write enables are 0, and `addr_o`, `src_lo_o` and `len_o` are 0.
- R2: A slot causes no write and no register change unless `dma_en_i` is 1 and the run flag is set. A `start_i` pulse while idle sets the run flag and latches `fill_data_i`.
- R3: `src_hi_i[7:6]` selects the mode: 00 and 01 select transfer, 10 selects fill, 11 selects copy. `target_i` selects the destination: 00 VRAM, 01 colour table, 10 scroll table, 11 none (the engine steps but writes nothing).
- R4: A transfer fetch raises `ext_req_o` with `ext_addr_o` = {`src_hi_i`, `src_mid_i`, `src_lo_o`}. The request stays high until `ext_valid_i` is seen, and slots that arrive meanwhile are ignored.
- R5: A transfer to VRAM writes the fetched word's high byte at `addr_o` in the cycle that `ext_valid_i` is high. The next slot writes the low byte at `addr_o` with bit 0 inverted.
- R6: A transfer to the colour table writes the whole word in the valid cycle at index `addr_o[6:1]`. For the scroll table the index is `addr_o[6:1]`, and the word is written only if that index is below 40.
- R7: A fill to VRAM writes the datum's low byte at `addr_o` in one slot. The next slot writes the high byte at `addr_o` with bit 0 inverted. Fills to either table write the whole datum in a single slot.
- R8: A copy spends one slot reading and the next slot writing the value it read. The read address is {`src_mid_i`, `src_lo_o`} for VRAM (byte, zero-extended), `src_lo_o[5:0]` for either table, and scroll-table reads at an index of 40 or more give 0.
- R9: After each completed unit, `addr_o` increases by `autoinc_i` modulo 2^16, `src_lo_o` increases by 1 modulo 256, and `len_o` decreases by 1. At all other times these registers hold their value unless loaded.
- R10: The run flag clears when `len_o` goes from 1 to 0. A count of 0 at start runs 65536 units.
- R11: `busy_o` is 1 exactly while the run flag is set.
- R12: A `start_i` pulse while the run flag is set is ignored, and the latched fill datum is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en_i | input | 1 | DMA enable bit from the mode register |
| slot_i | input | 1 | One free memory-access slot |
| start_i | input | 1 | Start pulse; sets the run flag when idle |
| fill_data_i | input | 16 | Datum latched at start (used by fill) |
| target_i | input | 2 | Destination select |
| src_hi_i | input | 8 | Source high byte; bits 7:6 give the mode |
| src_mid_i | input | 8 | Source middle byte |
| autoinc_i | input | 8 | Destination address step |
| ld_addr_i | input | 1 | Load strobe for the destination address |
| addr_i | input | 16 | Destination address load value |
| ld_src_lo_i | input | 1 | Load strobe for the source low byte |
| src_lo_i | input | 8 | Source low byte load value |
| ld_len_i | input | 1 | Load strobe for the unit count |
| len_i | input | 16 | Unit count load value |
| addr_o | output | 16 | Destination address register |
| src_lo_o | output | 8 | Source low byte register |
| len_o | output | 16 | Unit count register |
| busy_o | output | 1 | Run flag (DMA-active status bit) |
| ext_req_o | output | 1 | External read request |
| ext_addr_o | output | 24 | External read address |
| ext_valid_i | input | 1 | External read data valid |
| ext_data_i | input | 16 | External read data |
| vram_we_o | output | 1 | VRAM byte write enable |
| vram_addr_o | output | 16 | VRAM write address |
| vram_wdata_o | output | 8 | VRAM write byte |
| vram_raddr_o | output | 16 | VRAM copy read address |
| vram_rdata_i | input | 8 | VRAM copy read byte (combinational) |
| pal_we_o | output | 1 | Colour-table write enable |
| pal_idx_o | output | 6 | Colour-table write index |
| pal_wdata_o | output | 16 | Colour-table write word |
| pal_raddr_o | output | 6 | Colour-table copy read index |
| pal_rdata_i | input | 16 | Colour-table copy read word |
| scr_we_o | output | 1 | Scroll-table write enable |
| scr_idx_o | output | 6 | Scroll-table write index |
| scr_wdata_o | output | 16 | Scroll-table write word |
| scr_raddr_o | output | 6 | Scroll-table copy read index |
| scr_rdata_i | input | 16 | Scroll-table copy read word |

## Verification
The bench checks the byte order of both VRAM modes. A design that swapped the order would write the high byte of a fill first, or would send the second transfer byte to the wrong address; either shows up as a write that does not match. It starts a transfer with the source low byte at 0xFE to cover the 8-bit wrap, and it fires stray slots during a stalled fetch. A design that let the carry reach the middle byte would fetch from the wrong address, and one that did not stall would issue extra writes. It also checks the scroll-table bound for both writes and copy reads, the start pulse that must be ignored while busy, and a count of zero. A design that treated zero as an empty job would go idle after one slot instead of running all 65536 units.

// File: rtl/vdp_dma_pkg.sv
package vdp_dma_pkg;

  typedef enum logic [1:0] {
    TGT_VRAM = 2'b00,
    TGT_PAL  = 2'b01,
    TGT_SCR  = 2'b10,
    TGT_NONE = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    MODE_XFER = 2'd0,
    MODE_FILL = 2'd1,
    MODE_COPY = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_FETCH,      // issue external read
    ACT_XFER_HI,    // fetched word arrived, VRAM high byte
    ACT_XFER_LO,    // VRAM low byte from latch
    ACT_XFER_WORD,  // fetched word arrived, table write
    ACT_FILL_LO,
    ACT_FILL_HI,
    ACT_FILL_WORD,
    ACT_COPY_RD,
    ACT_COPY_WR
  } act_e;

  function automatic mode_e decode_mode(input logic [1:0] sel);
    if (!sel[1])    return MODE_XFER;
    else if (!sel[0]) return MODE_FILL;
    else            return MODE_COPY;
  endfunction

  function automatic logic [23:0] ext_src(input logic [7:0] hi,
                                          input logic [7:0] mid,
                                          input logic [7:0] lo);
    return {hi, mid, lo};
  endfunction

  // True for the action that finishes one unit of the job.
  function automatic logic closes_unit(input act_e a);
    return (a == ACT_XFER_LO) || (a == ACT_XFER_WORD) || (a == ACT_FILL_HI) ||
           (a == ACT_FILL_WORD) || (a == ACT_COPY_WR);
  endfunction

endpackage

// File: rtl/vdp_dma_ctrl.sv
module vdp_dma_ctrl
  import vdp_dma_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic              dma_en_i,
  input  logic              start_i,
  input  mode_e             mode_i,
  input  tgt_e              tgt_i,
  input  logic              ext_valid_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] fill_data_i,
  input  logic [WORD_W-1:0] ext_data_i,
  input  logic [WORD_W-1:0] copy_data_i,
  output act_e              act_o,
  output logic              unit_done_o,
  output logic              run_o,
  output logic              pend_o,
  output logic [WORD_W-1:0] val_o
);

  logic run_q, pend_q, half_q;
  logic [WORD_W-1:0] val_q;
  logic is_vram, step, last_unit;
  act_e act;

  assign is_vram = (tgt_i == TGT_VRAM);
  assign step    = run_q && dma_en_i && slot_i && !pend_q;

  always_comb begin
    act = ACT_NONE;
    if (pend_q) begin
      if (ext_valid_i) act = is_vram ? ACT_XFER_HI : ACT_XFER_WORD;
    end else if (step) begin
      case (mode_i)
        MODE_XFER: act = (is_vram && half_q) ? ACT_XFER_LO : ACT_FETCH;
        MODE_FILL: act = !is_vram ? ACT_FILL_WORD : (half_q ? ACT_FILL_HI : ACT_FILL_LO);
        MODE_COPY: act = half_q ? ACT_COPY_WR : ACT_COPY_RD;
        default:   act = ACT_NONE;
      endcase
    end
  end

  assign unit_done_o = closes_unit(act);
  assign last_unit   = unit_done_o && (len_i == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      half_q <= 1'b0;
      val_q  <= '0;
    end else if (start_i && !run_q) begin
      run_q  <= 1'b1;
      half_q <= 1'b0;
      val_q  <= fill_data_i;
    end else begin
      if (last_unit) run_q <= 1'b0;
      case (act)
        ACT_FETCH:     pend_q <= 1'b1;
        ACT_XFER_HI:   begin pend_q <= 1'b0; half_q <= 1'b1; val_q <= ext_data_i; end
        ACT_XFER_WORD: pend_q <= 1'b0;
        ACT_FILL_LO:   half_q <= 1'b1;
        ACT_COPY_RD:   begin half_q <= 1'b1; val_q <= copy_data_i; end
        default:       ;
      endcase
      if (unit_done_o) half_q <= 1'b0;
    end
  end

  assign act_o  = act;
  assign run_o  = run_q;
  assign pend_o = pend_q;
  assign val_o  = val_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !ext_valid_i |=> pend_q); // R4
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> act == ACT_NONE); // R2
  AST_LAST_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    last_unit |=> !run_q); // R10
  AST_START_KEEPS_DATUM: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && start_i && mode_i == MODE_FILL |=> val_q == $past(val_q)); // R12

endmodule

// File: rtl/vdp_dma_regs.sv
module vdp_dma_regs #(
  parameter int ADDR_W = 16,
  parameter int AINC_W = 8,
  parameter int SRC_W  = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [AINC_W-1:0] autoinc_i,
  input  logic              ld_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_src_lo_i,
  input  logic [SRC_W-1:0]  src_lo_i,
  input  logic              ld_len_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SRC_W-1:0]  src_lo_o,
  output logic [LEN_W-1:0]  len_o
);

  function automatic logic [ADDR_W-1:0] bump_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [AINC_W-1:0] inc);
    return a + ADDR_W'(inc);
  endfunction

  function automatic logic [LEN_W-1:0] drop_len(input logic [LEN_W-1:0] n);
    return n - LEN_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o   <= '0;
      src_lo_o <= '0;
      len_o    <= '0;
    end else begin
      if (ld_addr_i)        addr_o <= addr_i;
      else if (step_i)      addr_o <= bump_addr(addr_o, autoinc_i);
      if (ld_src_lo_i)      src_lo_o <= src_lo_i;
      else if (step_i)      src_lo_o <= src_lo_o + SRC_W'(1);
      if (ld_len_i)         len_o <= len_i;
      else if (step_i)      len_o <= drop_len(len_o);
    end
  end

  AST_SRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !ld_src_lo_i && (&src_lo_o) |=> src_lo_o == '0); // R9
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !ld_len_i |=> $stable(len_o)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !ld_addr_i |=> $stable(addr_o)); // R9

endmodule

// File: rtl/vdp_dma_memif.sv
module vdp_dma_memif
  import vdp_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SRC_W     = 8,
  parameter int WORD_W    = 16,
  parameter int PAL_DEPTH = 64,
  parameter int SCR_DEPTH = 40,
  parameter int SCR_SPAN  = 64,
  localparam int BYTE_W   = WORD_W / 2,
  localparam int PAL_IW   = $clog2(PAL_DEPTH),
  localparam int SCR_IW   = $clog2(SCR_SPAN)
) (
  input  act_e              act_i,
  input  tgt_e              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] val_i,
  input  logic [WORD_W-1:0] ext_data_i,
  input  logic [SRC_W-1:0]  src_mid_i,
  input  logic [SRC_W-1:0]  src_lo_i,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [BYTE_W-1:0] vram_wdata_o,
  output logic [ADDR_W-1:0] vram_raddr_o,
  input  logic [BYTE_W-1:0] vram_rdata_i,
  output logic              pal_we_o,
  output logic [PAL_IW-1:0] pal_idx_o,
  output logic [WORD_W-1:0] pal_wdata_o,
  output logic [PAL_IW-1:0] pal_raddr_o,
  input  logic [WORD_W-1:0] pal_rdata_i,
  output logic              scr_we_o,
  output logic [SCR_IW-1:0] scr_idx_o,
  output logic [WORD_W-1:0] scr_wdata_o,
  output logic [SCR_IW-1:0] scr_raddr_o,
  input  logic [WORD_W-1:0] scr_rdata_i,
  output logic [WORD_W-1:0] copy_data_o
);

  function automatic logic scr_in_range(input logic [SCR_IW-1:0] idx);
    return {1'b0, idx} < (SCR_IW+1)'(SCR_DEPTH);
  endfunction

  logic word_act;
  logic [WORD_W-1:0] word_data;
  logic [ADDR_W-1:0] addr_pair;

  assign addr_pair = addr_i ^ ADDR_W'(1);
  assign word_act  = (act_i == ACT_XFER_WORD) || (act_i == ACT_FILL_WORD) ||
                     (act_i == ACT_COPY_WR);
  assign word_data = (act_i == ACT_XFER_WORD) ? ext_data_i : val_i;

  always_comb begin
    vram_we_o    = 1'b0;
    vram_addr_o  = addr_i;
    vram_wdata_o = val_i[BYTE_W-1:0];
    case (act_i)
      ACT_XFER_HI: begin vram_we_o = 1'b1; vram_wdata_o = ext_data_i[WORD_W-1:BYTE_W]; end
      ACT_XFER_LO: begin vram_we_o = 1'b1; vram_addr_o = addr_pair; end
      ACT_FILL_LO: vram_we_o = 1'b1;
      ACT_FILL_HI: begin vram_we_o = 1'b1; vram_addr_o = addr_pair;
                         vram_wdata_o = val_i[WORD_W-1:BYTE_W]; end
      ACT_COPY_WR: vram_we_o = 1'b1;
      default:     ;
    endcase
    if (tgt_i != TGT_VRAM) vram_we_o = 1'b0;
  end

  assign pal_idx_o   = addr_i[PAL_IW:1];
  assign pal_wdata_o = word_data;
  assign pal_we_o    = word_act && (tgt_i == TGT_PAL);

  assign scr_idx_o   = addr_i[SCR_IW:1];
  assign scr_wdata_o = word_data;
  assign scr_we_o    = word_act && (tgt_i == TGT_SCR) && scr_in_range(scr_idx_o);

  assign vram_raddr_o = ADDR_W'({src_mid_i, src_lo_i});
  assign pal_raddr_o  = src_lo_i[PAL_IW-1:0];
  assign scr_raddr_o  = src_lo_i[SCR_IW-1:0];

  always_comb begin
    case (tgt_i)
      TGT_VRAM: copy_data_o = WORD_W'(vram_rdata_i);
      TGT_PAL:  copy_data_o = pal_rdata_i;
      TGT_SCR:  copy_data_o = scr_in_range(scr_raddr_o) ? scr_rdata_i : '0;
      default:  copy_data_o = '0;
    endcase
  end

endmodule

// File: rtl/vdp_dma_engine.sv
module vdp_dma_engine
  import vdp_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int PAL_DEPTH = 64,
  parameter int SCR_DEPTH = 40,
  parameter int SCR_SPAN  = 64,
  localparam int SRC_W    = 8,
  localparam int WORD_W   = 16,
  localparam int BYTE_W   = WORD_W / 2,
  localparam int EXT_W    = 3 * SRC_W,
  localparam int PAL_IW   = $clog2(PAL_DEPTH),
  localparam int SCR_IW   = $clog2(SCR_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en_i,
  input  logic              slot_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] fill_data_i,
  input  logic [1:0]        target_i,
  input  logic [SRC_W-1:0]  src_hi_i,
  input  logic [SRC_W-1:0]  src_mid_i,
  input  logic [SRC_W-1:0]  autoinc_i,
  input  logic              ld_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_src_lo_i,
  input  logic [SRC_W-1:0]  src_lo_i,
  input  logic              ld_len_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SRC_W-1:0]  src_lo_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              busy_o,
  output logic              ext_req_o,
  output logic [EXT_W-1:0]  ext_addr_o,
  input  logic              ext_valid_i,
  input  logic [WORD_W-1:0] ext_data_i,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [BYTE_W-1:0] vram_wdata_o,
  output logic [ADDR_W-1:0] vram_raddr_o,
  input  logic [BYTE_W-1:0] vram_rdata_i,
  output logic              pal_we_o,
  output logic [PAL_IW-1:0] pal_idx_o,
  output logic [WORD_W-1:0] pal_wdata_o,
  output logic [PAL_IW-1:0] pal_raddr_o,
  input  logic [WORD_W-1:0] pal_rdata_i,
  output logic              scr_we_o,
  output logic [SCR_IW-1:0] scr_idx_o,
  output logic [WORD_W-1:0] scr_wdata_o,
  output logic [SCR_IW-1:0] scr_raddr_o,
  input  logic [WORD_W-1:0] scr_rdata_i
);

  tgt_e  tgt;
  mode_e mode;
  act_e  act;
  logic  unit_done, run, pend;
  logic [WORD_W-1:0] val, copy_data;

  assign tgt  = tgt_e'(target_i);
  assign mode = decode_mode(src_hi_i[SRC_W-1:SRC_W-2]);

  vdp_dma_ctrl #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_ctrl (
    .clk, .rst_n, .slot_i, .dma_en_i, .start_i,
    .mode_i(mode), .tgt_i(tgt), .ext_valid_i, .len_i(len_o),
    .fill_data_i, .ext_data_i, .copy_data_i(copy_data),
    .act_o(act), .unit_done_o(unit_done), .run_o(run), .pend_o(pend), .val_o(val)
  );

  vdp_dma_regs #(.ADDR_W(ADDR_W), .AINC_W(SRC_W), .SRC_W(SRC_W), .LEN_W(LEN_W)) u_regs (
    .clk, .rst_n, .step_i(unit_done), .autoinc_i,
    .ld_addr_i, .addr_i, .ld_src_lo_i, .src_lo_i, .ld_len_i, .len_i,
    .addr_o, .src_lo_o, .len_o
  );

  vdp_dma_memif #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .WORD_W(WORD_W),
                  .PAL_DEPTH(PAL_DEPTH), .SCR_DEPTH(SCR_DEPTH), .SCR_SPAN(SCR_SPAN)) u_memif (
    .act_i(act), .tgt_i(tgt), .addr_i(addr_o), .val_i(val), .ext_data_i,
    .src_mid_i, .src_lo_i(src_lo_o),
    .vram_we_o, .vram_addr_o, .vram_wdata_o, .vram_raddr_o, .vram_rdata_i,
    .pal_we_o, .pal_idx_o, .pal_wdata_o, .pal_raddr_o, .pal_rdata_i,
    .scr_we_o, .scr_idx_o, .scr_wdata_o, .scr_raddr_o, .scr_rdata_i,
    .copy_data_o(copy_data)
  );

  assign busy_o     = run;
  assign ext_req_o  = pend;
  assign ext_addr_o = ext_src(src_hi_i, src_mid_i, src_lo_o);

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(vram_we_o || pal_we_o || scr_we_o)); // R2
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we_o, pal_we_o, scr_we_o})); // R3
  AST_SCR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    scr_we_o |-> {1'b0, scr_idx_o} < (SCR_IW+1)'(SCR_DEPTH)); // R6
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_o && !ext_valid_i |-> !(vram_we_o || pal_we_o || scr_we_o)); // R4
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_o |-> busy_o); // R11

endmodule

// File: tb/vdp_dma_engine_tb.sv
module vdp_dma_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en_i = 0, slot_i = 0, start_i = 0;
  logic [15:0] fill_data_i = '0;
  logic [1:0]  target_i = '0;
  logic [7:0]  src_hi_i = '0, src_mid_i = '0, autoinc_i = '0;
  logic ld_addr_i = 0, ld_src_lo_i = 0, ld_len_i = 0;
  logic [15:0] addr_i = '0, len_i = '0;
  logic [7:0]  src_lo_i = '0;
  logic [15:0] addr_o, len_o;
  logic [7:0]  src_lo_o;
  logic busy_o, ext_req_o, ext_valid_i = 0;
  logic [23:0] ext_addr_o;
  logic [15:0] ext_data_i = '0;
  logic vram_we_o, pal_we_o, scr_we_o;
  logic [15:0] vram_addr_o, vram_raddr_o;
  logic [7:0]  vram_wdata_o, vram_rdata_i;
  logic [5:0]  pal_idx_o, pal_raddr_o, scr_idx_o, scr_raddr_o;
  logic [15:0] pal_wdata_o, pal_rdata_i, scr_wdata_o, scr_rdata_i;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side data sources.
  function automatic logic [15:0] fext(input logic [23:0] a);
    return {a[7:0] ^ a[23:16], a[15:8]} ^ 16'h3C96;
  endfunction
  function automatic logic [7:0] fv(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction
  function automatic logic [15:0] fp(input logic [5:0] i);
    return 16'h7000 + 16'(i) * 16'd3;
  endfunction
  function automatic logic [15:0] fs(input logic [5:0] i);
    return 16'h4100 | 16'(i);
  endfunction

  assign vram_rdata_i = fv(vram_raddr_o);
  assign pal_rdata_i  = fp(pal_raddr_o);
  assign scr_rdata_i  = fs(scr_raddr_o);

  vdp_dma_engine u_dut (.*);

  // Scoreboard: port 0 VRAM, 1 colour table, 2 scroll table.
  typedef struct { int port; int addr; int data; string req; } wr_t;
  wr_t sb_q[$];

  task automatic expect_w(input int port, input int a, input int d, input string r);
    wr_t e; e.port = port; e.addr = a; e.data = d; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic observe(input int port, input int a, input int d);
    wr_t e;
    n_chk++;
    if (sb_q.size() == 0) begin
      n_fail++;
      $display("FAIL R2 unexpected write actual=port%0d @%0h=%0h expected=none", port, a, d);
    end else begin
      e = sb_q.pop_front();
      if (e.port != port || e.addr != a || e.data != d) begin
        n_fail++;
        $display("FAIL %s actual=port%0d @%0h=%0h expected=port%0d @%0h=%0h",
                 e.req, port, a, d, e.port, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (vram_we_o) observe(0, int'(vram_addr_o), int'(vram_wdata_o));
      if (pal_we_o)  observe(1, int'(pal_idx_o), int'(pal_wdata_o));
      if (scr_we_o)  observe(2, int'(scr_idx_o), int'(scr_wdata_o));
    end
  end

  // External bus: answer each request after a few cycles.
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (ext_req_o && !ext_valid_i) begin
        wait_cnt++;
        if (wait_cnt == 3) begin
          @(posedge clk); #1;
          ext_valid_i = 1'b1;
          ext_data_i  = fext(ext_addr_o);
          @(posedge clk); #1;
          ext_valid_i = 1'b0;
          wait_cnt    = 0;
        end
      end
    end
  end

  task automatic pulse_slot();
    @(posedge clk); #1 slot_i = 1'b1;
    @(posedge clk); #1 slot_i = 1'b0;
  endtask

  task automatic hold_slot(input int n);
    @(posedge clk); #1 slot_i = 1'b1;
    repeat (n) @(posedge clk);
    #1 slot_i = 1'b0;
  endtask

  task automatic start_job(input logic [15:0] d);
    @(posedge clk); #1 start_i = 1'b1; fill_data_i = d;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic load_regs(input logic [15:0] a, input logic [7:0] s, input logic [15:0] l);
    @(posedge clk); #1;
    ld_addr_i = 1; addr_i = a; ld_src_lo_i = 1; src_lo_i = s; ld_len_i = 1; len_i = l;
    @(posedge clk); #1;
    ld_addr_i = 0; ld_src_lo_i = 0; ld_len_i = 0;
  endtask

  task automatic run_to_idle();
    while (busy_o) begin
      pulse_slot();
      while (ext_req_o) pulse_slot();  // stray slots during a stall
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic sb_empty(input string r);
    chk({r, " pending expected writes"}, sb_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 req", ext_req_o, 0);
    chk("R1 we", {vram_we_o, pal_we_o, scr_we_o}, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 src_lo", src_lo_o, 0);
    chk("R1 len", len_o, 0);

    // R2 / R7 / R12: VRAM fill, first with enable low
    target_i = 2'b00; src_hi_i = 8'h80; autoinc_i = 8'd2;
    load_regs(16'h1000, 8'h10, 16'd3);
    start_job(16'hBEEF);
    chk("R11 busy after start", busy_o, 1);
    repeat (3) pulse_slot();
    chk("R2 len with enable low", len_o, 3);
    chk("R2 addr with enable low", addr_o, 16'h1000);
    for (int k = 0; k < 3; k++) begin
      expect_w(0, 16'h1000 + 2*k, 8'hEF, "R7 fill lo");
      expect_w(0, 16'h1001 + 2*k, 8'hBE, "R7 fill hi");
    end
    dma_en_i = 1'b1;
    pulse_slot();
    start_job(16'h1234);  // R12: ignored while busy
    run_to_idle();
    chk("R9 addr after fill", addr_o, 16'h1006);
    chk("R9 src_lo after fill", src_lo_o, 8'h13);
    chk("R10 len after fill", len_o, 0);
    chk("R11 busy after fill", busy_o, 0);
    sb_empty("R7");

    // R3 / R4 / R5 / R9: transfer to VRAM, mode bits 01, src_lo wraps
    src_hi_i = 8'h41; src_mid_i = 8'h22; autoinc_i = 8'd1;
    load_regs(16'h0101, 8'hFE, 16'd2);
    begin
      logic [15:0] d1, d2;
      d1 = fext(24'h4122FE); d2 = fext(24'h4122FF);
      expect_w(0, 16'h0101, d1[15:8], "R5 xfer hi (R3 R4)");
      expect_w(0, 16'h0100, d1[7:0],  "R5 xfer lo");
      expect_w(0, 16'h0102, d2[15:8], "R5 xfer hi (R4)");
      expect_w(0, 16'h0103, d2[7:0],  "R5 xfer lo");
    end
    start_job(16'h0000);
    run_to_idle();
    chk("R9 src_lo wrap", src_lo_o, 8'h00);
    chk("R9 addr after xfer", addr_o, 16'h0103);
    sb_empty("R5");

    // R6: transfer to colour table
    target_i = 2'b01; src_hi_i = 8'h00; autoinc_i = 8'd2;
    load_regs(16'h0086, 8'h30, 16'd2);
    expect_w(1, 3, fext(24'h002230), "R6 pal word");
    expect_w(1, 4, fext(24'h002231), "R6 pal word");
    start_job(16'h0000);
    run_to_idle();
    sb_empty("R6 pal");

    // R6: transfer to scroll table crossing the bound
    target_i = 2'b10;
    load_regs(16'h004E, 8'h40, 16'd2);
    expect_w(2, 39, fext(24'h002240), "R6 scr in range");
    start_job(16'h0000);
    run_to_idle();
    chk("R6 len after bounded xfer", len_o, 0);
    sb_empty("R6 scr");

    // R8: VRAM copy
    target_i = 2'b00; src_hi_i = 8'hC0; src_mid_i = 8'h12; autoinc_i = 8'd1;
    load_regs(16'h2000, 8'h34, 16'd2);
    expect_w(0, 16'h2000, fv(16'h1234), "R8 vram copy");
    expect_w(0, 16'h2001, fv(16'h1235), "R8 vram copy");
    start_job(16'h0000);
    run_to_idle();
    sb_empty("R8 vram");

    // R8: scroll-table copy, second read out of range gives 0
    target_i = 2'b10; autoinc_i = 8'd2;
    load_regs(16'h0000, 8'h27, 16'd2);
    expect_w(2, 0, fs(6'd39), "R8 scr copy");
    expect_w(2, 1, 0, "R8 scr copy out of range");
    start_job(16'h0000);
    run_to_idle();
    sb_empty("R8 scr");

    // R8: colour-table copy with masked read index
    target_i = 2'b01;
    load_regs(16'h0002, 8'h41, 16'd1);
    expect_w(1, 1, fp(6'd1), "R8 pal copy");
    start_job(16'h0000);
    run_to_idle();
    sb_empty("R8 pal");

    // R7: colour-table fill, one word per slot
    src_hi_i = 8'h80;
    load_regs(16'h0010, 8'h00, 16'd1);
    expect_w(1, 8, 16'h0ACE, "R7 pal fill");
    start_job(16'h0ACE);
    run_to_idle();
    sb_empty("R7 pal");

    // R10: count 0 runs 65536 units (target none writes nothing)
    target_i = 2'b11;
    load_regs(16'h0000, 8'h00, 16'd0);
    start_job(16'h5555);
    hold_slot(65535);
    @(negedge clk);
    chk("R10 busy after 65535 units", busy_o, 1);
    chk("R10 len after 65535 units", len_o, 1);
    pulse_slot();
    @(negedge clk);
    chk("R10 busy after 65536 units", busy_o, 0);
    chk("R10 len after 65536 units", len_o, 0);
    chk("R3 target none src_lo", src_lo_o, 8'h00);
    sb_empty("R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule